// File: doc/BRIEF.md
# Multi-Slope Conversion Sequencer

This block is the digital controller of a multi-slope integrating converter. It turns the oscillator clock into a slower count clock. It then runs a fixed frame of 1280 counts, one phase after another. The first phase nulls the analog front end. The second integrates the unknown input for a fixed time. The third removes the stored charge against a reference. That last part is done in stages: a coarse stage, a fine stage and, when the input is above full scale, up to three extra stages. Because the frame length is fixed, every conversion takes the same time whatever the input level.

The controller drives one switch-control line per phase. It samples a one-bit comparator once per count. A change of comparator level closes the de-integrate stage that is running. The coarse and fine stage lengths are packed into a 15-bit code. The overrange length is reported in a separate field together with a flag. At each frame boundary the controller publishes a fresh result, pulses a done strobe and starts over.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The count clock is the input clock divided by 4. Every control change and every done pulse starts on a count boundary, and done stays high for exactly 4 input clocks.
- R2: Each frame opens with 246 counts during which zero_loop_o and in_open_o are high and every other phase control is low.
- R3: Right after that comes the signal phase: 256 counts with in_conn_o high as the only phase control.
- R4: The reference part of the frame always lasts 778 counts. Its first 10 counts have no phase control high. A whole frame is therefore 1280 counts from one done pulse to the next.
- R5: deint_fast_o is high for K+1 counts, K in 0..511. K is the first count at which cmp_i differs from its level at the previous count; when no change occurs, K is 511. K appears in result_o[14:6].
- R6: deint_slow_o follows at once and is high for J+1 counts. J is found the same way, with a limit of 63, and appears in result_o[5:0]. The code is therefore K*64+J.
- R7: The overrange stage is entered only if the fine stage reaches its limit with no comparator change. It then holds deint_ovr_o high for M+1 counts, M in 0..191 (three stages of 64). It reports M on ovr_cnt_o and sets ovr_flag_o. With no overrange, both fields read 0.
- R8: Once de-integration has ended, no phase control is high until the frame ends, and comparator changes in that time have no effect on the result. At most one phase control is high at any time.
- R9: result_o, ovr_cnt_o and ovr_flag_o change only when done rises, at the start of the next frame's first count. Between those points they hold their values.
- R10: While rst_ni is low, the block sits at the start of the null phase: zero_loop_o and in_open_o are high, the other controls are low, done_o is low and all result fields are 0.
- R11: A comparator change in the final count of the fine stage counts as a zero crossing. J is 63 and no overrange stage follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 1 | Comparator level, synchronous to clk_i |
| zero_loop_o | output | 1 | Close the offset-nulling loop |
| in_open_o | output | 1 | Disconnect the input pins |
| in_conn_o | output | 1 | Connect the input pins to the integrator |
| deint_fast_o | output | 1 | Coarse reference de-integrate switch |
| deint_slow_o | output | 1 | Fine reference de-integrate switch |
| deint_ovr_o | output | 1 | Overrange de-integrate switch |
| done_o | output | 1 | Frame-complete strobe, one count long |
| result_o | output | 15 | Conversion code: coarse count x64 plus fine count |
| ovr_cnt_o | output | 8 | Overrange count |
| ovr_flag_o | output | 1 | Overrange stage was entered |

## Verification
A wrong divider or frame count shows up at the ports within one frame. The phase controls stay high for the wrong number of input clocks, and the gap between done pulses moves away from 5120 clocks. A wrong de-integrate capture shows up within the first frame after the comparator event, because the published code or the overrange field no longer matches the count at which the bench toggled cmp_i. A stage that runs past its limit shows up in the measured switch widths before the next done pulse.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  typedef enum logic [2:0] {
    PH_AZ   = 3'd0,
    PH_SI   = 3'd1,
    PH_SET  = 3'd2,
    PH_FAST = 3'd3,
    PH_SLOW = 3'd4,
    PH_OVR  = 3'd5,
    PH_WAIT = 3'd6
  } phase_e;
endpackage

// File: rtl/adc_tick_div.sv
`timescale 1ns/1ps
module adc_tick_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/adc_frame_ctr.sv
`timescale 1ns/1ps
module adc_frame_ctr #(
  parameter int unsigned FRAME = 1280,
  parameter int unsigned FW    = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  output logic [FW-1:0] fcnt_o,
  output logic          last_o
);
  assign last_o = (fcnt_o == FW'(FRAME - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fcnt_o <= '0;
    else if (tick_i) fcnt_o <= last_o ? '0 : fcnt_o + FW'(1);
  end
endmodule

// File: rtl/adc_deint_fsm.sv
`timescale 1ns/1ps
module adc_deint_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned AZ_CNT   = 246,
  parameter int unsigned SI_CNT   = 256,
  parameter int unsigned SET_CNT  = 10,
  parameter int unsigned FAST_CNT = 512,
  parameter int unsigned SLOW_CNT = 64,
  parameter int unsigned OVR_LEN  = 64,
  parameter int unsigned OVR_NUM  = 3,
  parameter int unsigned FW       = 11,
  parameter int unsigned FAST_W   = 9,
  parameter int unsigned SLOW_W   = 6,
  parameter int unsigned OVR_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [FW-1:0]     fcnt_i,
  input  logic              last_i,
  input  logic              cmp_i,
  output phase_e            phase_o,
  output logic [FAST_W-1:0] fast_o,
  output logic [SLOW_W-1:0] slow_o,
  output logic [OVR_W-1:0]  ovr_o,
  output logic              flag_o
);
  localparam int unsigned AZ_END  = AZ_CNT - 1;
  localparam int unsigned SI_END  = AZ_CNT + SI_CNT - 1;
  localparam int unsigned SET_END = AZ_CNT + SI_CNT + SET_CNT - 1;
  localparam int unsigned OVR_MAX = OVR_LEN * OVR_NUM;
  localparam int unsigned M1      = (FAST_CNT > OVR_MAX) ? FAST_CNT : OVR_MAX;
  localparam int unsigned M2      = (M1 > SLOW_CNT) ? M1 : SLOW_CNT;
  localparam int unsigned SUB_W   = $clog2(M2);

  phase_e            ph_q, ph_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [FAST_W-1:0] fast_q, fast_d;
  logic [SLOW_W-1:0] slow_q, slow_d;
  logic [OVR_W-1:0]  ovr_q, ovr_d;
  logic              flag_q, flag_d;
  logic              cmp_q, chg;

  // a level change between consecutive counts marks the zero crossing
  assign chg = cmp_i ^ cmp_q;

  always_comb begin
    ph_d   = ph_q;
    sub_d  = sub_q;
    fast_d = fast_q;
    slow_d = slow_q;
    ovr_d  = ovr_q;
    flag_d = flag_q;
    case (ph_q)
      PH_AZ:  if (fcnt_i == FW'(AZ_END)) ph_d = PH_SI;
      PH_SI:  if (fcnt_i == FW'(SI_END)) ph_d = PH_SET;
      PH_SET: if (fcnt_i == FW'(SET_END)) begin
        ph_d  = PH_FAST;
        sub_d = '0;
      end
      PH_FAST: begin
        if (chg || sub_q == SUB_W'(FAST_CNT - 1)) begin
          fast_d = sub_q[FAST_W-1:0];
          ph_d   = PH_SLOW;
          sub_d  = '0;
        end else begin
          sub_d = sub_q + SUB_W'(1);
        end
      end
      PH_SLOW: begin
        if (chg) begin
          slow_d = sub_q[SLOW_W-1:0];
          ph_d   = PH_WAIT;
        end else if (sub_q == SUB_W'(SLOW_CNT - 1)) begin
          slow_d = sub_q[SLOW_W-1:0];
          flag_d = 1'b1;
          ph_d   = PH_OVR;
          sub_d  = '0;
        end else begin
          sub_d = sub_q + SUB_W'(1);
        end
      end
      PH_OVR: begin
        // one running index across all overrange stages: 64*stage + offset
        if (chg || sub_q == SUB_W'(OVR_MAX - 1)) begin
          ovr_d = sub_q[OVR_W-1:0];
          ph_d  = PH_WAIT;
        end else begin
          sub_d = sub_q + SUB_W'(1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_AZ;
      sub_q  <= '0;
      fast_q <= '0;
      slow_q <= '0;
      ovr_q  <= '0;
      flag_q <= 1'b0;
      cmp_q  <= 1'b0;
    end else if (tick_i) begin
      cmp_q <= cmp_i;
      if (last_i) begin
        ph_q   <= PH_AZ;
        sub_q  <= '0;
        fast_q <= '0;
        slow_q <= '0;
        ovr_q  <= '0;
        flag_q <= 1'b0;
      end else begin
        ph_q   <= ph_d;
        sub_q  <= sub_d;
        fast_q <= fast_d;
        slow_q <= slow_d;
        ovr_q  <= ovr_d;
        flag_q <= flag_d;
      end
    end
  end

  // next-state values so a capture in the frame's last count is published
  assign phase_o = ph_q;
  assign fast_o  = fast_d;
  assign slow_o  = slow_d;
  assign ovr_o   = ovr_d;
  assign flag_o  = flag_d;
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned DIV      = 4,
  parameter int unsigned AZ_CNT   = 246,
  parameter int unsigned SI_CNT   = 256,
  parameter int unsigned SET_CNT  = 10,
  parameter int unsigned FAST_CNT = 512,
  parameter int unsigned SLOW_CNT = 64,
  parameter int unsigned OVR_LEN  = 64,
  parameter int unsigned OVR_NUM  = 3,
  localparam int unsigned FAST_W  = $clog2(FAST_CNT),
  localparam int unsigned SLOW_W  = $clog2(SLOW_CNT),
  localparam int unsigned RES_W   = FAST_W + SLOW_W,
  localparam int unsigned OVR_MAX = OVR_LEN * OVR_NUM,
  localparam int unsigned OVR_W   = $clog2(OVR_MAX),
  localparam int unsigned REF_CNT = SET_CNT + FAST_CNT + SLOW_CNT + OVR_MAX,
  localparam int unsigned FRAME   = AZ_CNT + SI_CNT + REF_CNT,
  localparam int unsigned FW      = $clog2(FRAME)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_i,
  output logic             zero_loop_o,
  output logic             in_open_o,
  output logic             in_conn_o,
  output logic             deint_fast_o,
  output logic             deint_slow_o,
  output logic             deint_ovr_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o,
  output logic [OVR_W-1:0] ovr_cnt_o,
  output logic             ovr_flag_o
);
  logic              tick, last;
  logic [FW-1:0]     fcnt;
  phase_e            phase;
  logic [FAST_W-1:0] fast_v;
  logic [SLOW_W-1:0] slow_v;
  logic [OVR_W-1:0]  ovr_v;
  logic              flag_v;

  adc_tick_div #(.DIV(DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  adc_frame_ctr #(.FRAME(FRAME), .FW(FW)) u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .fcnt_o (fcnt),
    .last_o (last)
  );

  adc_deint_fsm #(
    .AZ_CNT   (AZ_CNT),
    .SI_CNT   (SI_CNT),
    .SET_CNT  (SET_CNT),
    .FAST_CNT (FAST_CNT),
    .SLOW_CNT (SLOW_CNT),
    .OVR_LEN  (OVR_LEN),
    .OVR_NUM  (OVR_NUM),
    .FW       (FW),
    .FAST_W   (FAST_W),
    .SLOW_W   (SLOW_W),
    .OVR_W    (OVR_W)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .fcnt_i  (fcnt),
    .last_i  (last),
    .cmp_i   (cmp_i),
    .phase_o (phase),
    .fast_o  (fast_v),
    .slow_o  (slow_v),
    .ovr_o   (ovr_v),
    .flag_o  (flag_v)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      result_o   <= '0;
      ovr_cnt_o  <= '0;
      ovr_flag_o <= 1'b0;
    end else if (tick) begin
      done_o <= last;
      if (last) begin
        result_o   <= {fast_v, slow_v};
        ovr_cnt_o  <= ovr_v;
        ovr_flag_o <= flag_v;
      end
    end
  end

  assign zero_loop_o  = (phase == PH_AZ);
  assign in_open_o    = (phase == PH_AZ);
  assign in_conn_o    = (phase == PH_SI);
  assign deint_fast_o = (phase == PH_FAST);
  assign deint_slow_o = (phase == PH_SLOW);
  assign deint_ovr_o  = (phase == PH_OVR);
endmodule

// File: rtl/adc_seq_chk.sv
`timescale 1ns/1ps
module adc_seq_chk #(
  parameter int unsigned DIV      = 4,
  parameter int unsigned AZ_CNT   = 246,
  parameter int unsigned FAST_CNT = 512,
  parameter int unsigned FRAME    = 1280,
  parameter int unsigned RES_W    = 15,
  parameter int unsigned OVR_W    = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             zero_loop_o,
  input logic             in_conn_o,
  input logic             deint_fast_o,
  input logic             deint_slow_o,
  input logic             deint_ovr_o,
  input logic             done_o,
  input logic [RES_W-1:0] result_o,
  input logic [OVR_W-1:0] ovr_cnt_o,
  input logic             ovr_flag_o
);
  int unsigned az_run, done_run, fast_run, frm_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      az_run   <= 0;
      done_run <= 0;
      fast_run <= 0;
      frm_run  <= 0;
    end else begin
      az_run   <= zero_loop_o  ? az_run + 1   : 0;
      done_run <= done_o       ? done_run + 1 : 0;
      fast_run <= deint_fast_o ? fast_run + 1 : 0;
      frm_run  <= (done_o && done_run == 0) ? 1 : frm_run + 1;
    end
  end

  p_az_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(zero_loop_o) |-> az_run == AZ_CNT * DIV);

  p_frame_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> frm_run == FRAME * DIV);

  p_done_width_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> done_run == DIV);

  p_fast_limit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deint_fast_o |-> fast_run < FAST_CNT * DIV);

  p_slow_after_fast_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(deint_slow_o) |-> $past(deint_fast_o));

  p_ovr_after_slow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(deint_ovr_o) |-> $past(deint_slow_o));

  p_ovr_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovr_flag_o |-> ovr_cnt_o == '0);

  p_phase_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({zero_loop_o, in_conn_o, deint_fast_o, deint_slow_o, deint_ovr_o}));

  p_result_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(done_o) |-> $stable(result_o) && $stable(ovr_cnt_o) && $stable(ovr_flag_o));
endmodule

bind adc_seq_ctrl adc_seq_chk #(
  .DIV      (DIV),
  .AZ_CNT   (AZ_CNT),
  .FAST_CNT (FAST_CNT),
  .FRAME    (FRAME),
  .RES_W    (RES_W),
  .OVR_W    (OVR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .zero_loop_o  (zero_loop_o),
  .in_conn_o    (in_conn_o),
  .deint_fast_o (deint_fast_o),
  .deint_slow_o (deint_slow_o),
  .deint_ovr_o  (deint_ovr_o),
  .done_o       (done_o),
  .result_o     (result_o),
  .ovr_cnt_o    (ovr_cnt_o),
  .ovr_flag_o   (ovr_flag_o)
);

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmp = 1'b0;
  logic        zero_loop_o, in_open_o, in_conn_o;
  logic        deint_fast_o, deint_slow_o, deint_ovr_o, done_o;
  logic [14:0] result_o;
  logic [7:0]  ovr_cnt_o;
  logic        ovr_flag_o;

  int n_chk = 0;
  int n_fail = 0;

  adc_seq_ctrl uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .cmp_i        (cmp),
    .zero_loop_o  (zero_loop_o),
    .in_open_o    (in_open_o),
    .in_conn_o    (in_conn_o),
    .deint_fast_o (deint_fast_o),
    .deint_slow_o (deint_slow_o),
    .deint_ovr_o  (deint_ovr_o),
    .done_o       (done_o),
    .result_o     (result_o),
    .ovr_cnt_o    (ovr_cnt_o),
    .ovr_flag_o   (ovr_flag_o)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-frame width monitor, counted in input clocks at negedges
  int c_az, c_si, c_set, c_fast, c_slow, c_ovr, c_done, c_all;
  int s_az, s_si, s_set, s_fast, s_slow, s_ovr, s_done, s_all;
  int frames;
  logic done_d, seen_fast;

  always @(negedge clk) begin
    if (!rst_ni) begin
      c_az = 0; c_si = 0; c_set = 0; c_fast = 0; c_slow = 0; c_ovr = 0; c_done = 0; c_all = 0;
      frames = 0; done_d = 1'b0; seen_fast = 1'b0;
    end else begin
      if (done_o && !done_d) begin
        s_az = c_az; s_si = c_si; s_set = c_set; s_fast = c_fast;
        s_slow = c_slow; s_ovr = c_ovr; s_done = c_done; s_all = c_all;
        c_az = 0; c_si = 0; c_set = 0; c_fast = 0; c_slow = 0; c_ovr = 0; c_done = 0; c_all = 0;
        seen_fast = 1'b0;
        frames++;
      end
      c_all++;
      if (zero_loop_o) c_az++;
      if (in_conn_o) c_si++;
      if (deint_fast_o) begin c_fast++; seen_fast = 1'b1; end
      if (deint_slow_o) c_slow++;
      if (deint_ovr_o) c_ovr++;
      if (!seen_fast && !zero_loop_o && !in_conn_o) c_set++;
      if (done_o) c_done++;
      done_d = done_o;
    end
  end

  int prev_res = 0;
  int prev_ovr = 0;

  // k, j, m: count index at which cmp toggles in each stage, -1 for none
  task automatic run_frame(input string tag, input int k, input int j, input int m, input bit noise);
    int fk, sj, om, exp_res, exp_ovr, held_res, held_ovr;
    bit ovr_on;
    fk = (k < 0) ? 511 : k;
    sj = (j < 0) ? 63 : j;
    ovr_on = (j < 0);
    om = ovr_on ? ((m < 0) ? 191 : m) : 0;
    exp_res = fk * 64 + sj;
    exp_ovr = om;
    while (!deint_fast_o) @(negedge clk);
    if (k >= 0) begin repeat (4 * k) @(negedge clk); cmp = ~cmp; end
    while (!deint_slow_o) @(negedge clk);
    if (j >= 0) begin repeat (4 * j) @(negedge clk); cmp = ~cmp; end
    if (ovr_on) begin
      while (!deint_ovr_o) @(negedge clk);
      if (m >= 0) begin repeat (4 * m) @(negedge clk); cmp = ~cmp; end
    end else if (noise) begin
      while (deint_slow_o) @(negedge clk);
      for (int i = 0; i < 5; i++) begin repeat (12) @(negedge clk); cmp = ~cmp; end
    end
    held_res = result_o;
    held_ovr = ovr_cnt_o;
    while (!done_o) begin
      held_res = result_o;
      held_ovr = ovr_cnt_o;
      @(negedge clk);
    end
    chk("R9", {tag, " result held before done"}, held_res, prev_res);
    chk("R9", {tag, " ovr held before done"}, held_ovr, prev_ovr);
    chk("R5 R6", {tag, " result"}, int'(result_o), exp_res);
    chk("R5", {tag, " coarse field"}, int'(result_o[14:6]), fk);
    chk("R6", {tag, " fine field"}, int'(result_o[5:0]), sj);
    chk("R7", {tag, " ovr count"}, int'(ovr_cnt_o), exp_ovr);
    chk("R7", {tag, " ovr flag"}, int'(ovr_flag_o), int'(ovr_on));
    @(negedge clk);
    chk("R2", {tag, " null width"}, s_az, 984);
    chk("R3", {tag, " signal width"}, s_si, 1024);
    chk("R4", {tag, " settle gap"}, s_set, 40);
    chk("R4", {tag, " frame length"}, s_all, 5120);
    chk("R5", {tag, " coarse width"}, s_fast, 4 * (fk + 1));
    chk("R6", {tag, " fine width"}, s_slow, 4 * (sj + 1));
    chk("R7 R8", {tag, " ovr width"}, s_ovr, ovr_on ? 4 * (om + 1) : 0);
    if (frames >= 2) chk("R1", {tag, " done width"}, s_done, 4);
    prev_res = exp_res;
    prev_ovr = exp_ovr;
  endtask

  task automatic check_reset_state(input string tag);
    chk("R10", {tag, " zero loop"}, int'(zero_loop_o), 1);
    chk("R10", {tag, " input open"}, int'(in_open_o), 1);
    chk("R10", {tag, " other controls"},
        int'({in_conn_o, deint_fast_o, deint_slow_o, deint_ovr_o}), 0);
    chk("R10", {tag, " done"}, int'(done_o), 0);
    chk("R10", {tag, " result"}, int'(result_o), 0);
    chk("R10", {tag, " ovr fields"}, int'({ovr_cnt_o, ovr_flag_o}), 0);
  endtask

  task automatic test_power_on();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state("power-on");
    @(posedge clk);
    #1 rst_ni = 1'b1;
    prev_res = 0;
    prev_ovr = 0;
  endtask

  task automatic test_mid_reset();
    while (!deint_fast_o) @(negedge clk);
    repeat (20) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check_reset_state("mid-frame");
    cmp = ~cmp;
    repeat (3) @(negedge clk);
    check_reset_state("mid-frame cmp ignored");
    @(posedge clk);
    #1 rst_ni = 1'b1;
    prev_res = 0;
    prev_ovr = 0;
  endtask

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL R4 watchdog actual=timeout expected=frame completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    test_power_on();
    run_frame("crossing+wait noise R8", 5, 10, -1, 1'b1);
    run_frame("coarse limit", -1, 0, -1, 1'b0);
    run_frame("fine last count R11", 0, 63, -1, 1'b0);
    run_frame("full overrange", -1, -1, -1, 1'b0);
    run_frame("overrange stage 2", 300, -1, 70, 1'b0);
    run_frame("coarse last count", 511, 5, -1, 1'b0);
    test_mid_reset();
    run_frame("after reset", 1, 2, -1, 1'b0);
    run_frame("overrange stage 1", 17, -1, 0, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule